// File: doc/BRIEF.md
# Stereo Codec Serial Audio Port

This block is the digital audio port of a stereo codec. On the capture side it takes a left/right sample pair from the ADC filter through a valid/ready handshake and sends both words, time-multiplexed, out on one serial data line. A capture frame clock marks the halves: low for left, high for right. On the playback side it gathers left and right words from one serial input line, framed by a separate playback frame clock. It hands each finished pair to the DAC path through a second valid/ready handshake.

Both directions share one bit clock. In slave mode the bit clock comes in from a pin. In master mode the block divides the master clock down to make the bit clock and enables the pin driver. Every serial input, and the bit clock itself, passes through a two-flop synchronizer into the master-clock domain. Edge detectors then drive the shifters, so each bit-clock phase must last at least four master-clock periods. The data and frame clock must change with the bit clock's falling edge.

Each word starts with its MSB in the second bit-clock period after a frame-clock transition. Word length is selectable. Parallel samples are right-aligned. Serial slots that carry no data bit hold zero on capture and are ignored on playback. If no capture pair is offered when a frame starts, the block sends the previous pair again and sets a sticky underrun flag.

Top module: `codec_audio_port`

## Requirements
- R1: After reset, adc_dat, cap_ready, play_valid and underrun are all 0.
- R2: The capture line changes only just after a detected bit-clock falling edge. In the second bit-clock period after a capture frame-clock transition it carries the MSB of the current channel word, then the lower bits in order. The left word is sent while adc_lrc is low and the right word while it is high.
- R3: word_sel selects the word length W: 0 gives 16, 1 gives 20, 2 gives 24 and 3 gives 32 bits. Parallel samples occupy bits W-1:0. Capture ignores the bits above W, and playback outputs hold them at zero.
- R4: On capture, adc_dat is 0 in the first bit-clock period of each half-frame and in every period after the W data bits.
- R5: cap_ready is high for exactly one master-clock cycle at each falling transition of adc_lrc, which starts a frame. If cap_valid is high in that cycle, that cap_left/cap_right pair is the one sent during the frame.
- R6: If cap_valid is low when cap_ready is high, the previous pair is sent again and underrun goes to 1. Underrun stays at 1 until reset.
- R7: Playback bits are sampled on bit-clock rising edges. The sample in the second period after a dac_lrc transition is the MSB of a W-bit word, sent left while dac_lrc is low. The first period and all periods after the W bits are ignored.
- R8: After the last bit of a right word arrives, play_left/play_right show that frame's pair and play_valid is 1. The pair stays stable until a cycle in which play_ready is 1. A newer pair replaces an unaccepted one. A new pair arriving in the same cycle as acceptance leaves play_valid set.
- R9: With master_mode at 1, bclk_oe is 1 and bclk_out toggles every BCLK_HALF master clocks, and both paths follow that clock. With master_mode at 0, bclk_oe is 0 and bclk_in clocks the paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1: generate bit clock, 0: use bclk_in |
| word_sel | input | 2 | Word length select (16/20/24/32) |
| bclk_in | input | 1 | External bit clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| bclk_oe | output | 1 | Output enable for the bit-clock pin |
| adc_lrc | input | 1 | Capture frame clock, low = left |
| adc_dat | output | 1 | Capture serial data |
| cap_left | input | 32 | Capture left sample, right-aligned |
| cap_right | input | 32 | Capture right sample, right-aligned |
| cap_valid | input | 1 | Capture pair offered |
| cap_ready | output | 1 | Capture pair taken this cycle |
| underrun | output | 1 | Sticky: a frame started with no pair offered |
| dac_lrc | input | 1 | Playback frame clock, low = left |
| dac_dat | input | 1 | Playback serial data |
| play_left | output | 32 | Playback left sample, right-aligned |
| play_right | output | 32 | Playback right sample, right-aligned |
| play_valid | output | 1 | Playback pair available |
| play_ready | input | 1 | Consumer accepts the playback pair |

## Verification
Finishing a playback pair and accepting the previous one can fall in the same master-clock cycle. In that cycle the new pair must win, and no pair may be lost or duplicated. The bench provokes this by holding play_ready high through a whole frame, so the finished pair is accepted the moment it appears. It judges the result by counting accept cycles at the ports, checking the accepted values and confirming that play_valid falls again. A capture frame start can also coincide with a missing sample; that case is judged by the repeated serial words and the sticky underrun flag.

// File: rtl/codec_audio_port.sv
module codec_audio_port #(
  parameter int BCLK_HALF = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master_mode,
  input  logic [1:0]  word_sel,
  input  logic        bclk_in,
  output logic        bclk_out,
  output logic        bclk_oe,
  input  logic        adc_lrc,
  output logic        adc_dat,
  input  logic [31:0] cap_left,
  input  logic [31:0] cap_right,
  input  logic        cap_valid,
  output logic        cap_ready,
  output logic        underrun,
  input  logic        dac_lrc,
  input  logic        dac_dat,
  output logic [31:0] play_left,
  output logic [31:0] play_right,
  output logic        play_valid,
  input  logic        play_ready
);
  localparam int DW = (BCLK_HALF > 2) ? $clog2(BCLK_HALF) : 1;

  logic [DW-1:0] div_cnt;
  logic          bclk_gen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt  <= '0;
      bclk_gen <= 1'b0;
    end else if (!master_mode) begin
      div_cnt  <= '0;
      bclk_gen <= 1'b0;
    end else if (div_cnt == DW'(BCLK_HALF - 1)) begin
      div_cnt  <= '0;
      bclk_gen <= ~bclk_gen;
    end else begin
      div_cnt  <= div_cnt + DW'(1);
    end

  assign bclk_out = bclk_gen;
  assign bclk_oe  = master_mode;

  logic [2:0] bk;
  logic [1:0] alr, dlr, dd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bk  <= '0;
      alr <= '0;
      dlr <= '0;
      dd  <= '0;
    end else begin
      bk  <= {bk[1:0], master_mode ? bclk_gen : bclk_in};
      alr <= {alr[0], adc_lrc};
      dlr <= {dlr[0], dac_lrc};
      dd  <= {dd[0], dac_dat};
    end

  wire rise = bk[1] & ~bk[2];
  wire fall = ~bk[1] & bk[2];
  wire alrc = alr[1];
  wire dlrc = dlr[1];
  wire ddat = dd[1];

  logic [5:0] wlen;
  always_comb
    case (word_sel)
      2'd0:    wlen = 6'd16;
      2'd1:    wlen = 6'd20;
      2'd2:    wlen = 6'd24;
      default: wlen = 6'd32;
    endcase
  wire [5:0] lshift = 6'd32 - wlen;

  logic        tx_lr;
  logic [5:0]  tx_cnt;
  logic [31:0] tx_sh, hold_l, hold_r;

  assign cap_ready = fall && (alrc != tx_lr) && !alrc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_lr    <= 1'b0;
      tx_cnt   <= 6'd32;
      tx_sh    <= '0;
      hold_l   <= '0;
      hold_r   <= '0;
      adc_dat  <= 1'b0;
      underrun <= 1'b0;
    end else if (fall) begin
      if (alrc != tx_lr) begin
        tx_lr   <= alrc;
        tx_cnt  <= '0;
        adc_dat <= 1'b0;
        if (alrc)
          tx_sh <= hold_r << lshift;
        else if (cap_valid) begin
          hold_l <= cap_left;
          hold_r <= cap_right;
          tx_sh  <= cap_left << lshift;
        end else begin
          underrun <= 1'b1;
          tx_sh    <= hold_l << lshift;
        end
      end else if (tx_cnt < wlen) begin
        adc_dat <= tx_sh[31];
        tx_sh   <= {tx_sh[30:0], 1'b0};
        tx_cnt  <= tx_cnt + 6'd1;
      end else begin
        adc_dat <= 1'b0;
      end
    end

  logic        rx_lr;
  logic [5:0]  rx_cnt;
  logic [31:0] rx_sh, rx_l;

  wire        emit    = rise && (dlrc == rx_lr) && (rx_cnt == wlen - 6'd1);
  wire [31:0] rx_word = {rx_sh[30:0], ddat};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_lr  <= 1'b0;
      rx_cnt <= 6'd32;
      rx_sh  <= '0;
    end else if (rise) begin
      if (dlrc != rx_lr) begin
        rx_lr  <= dlrc;
        rx_cnt <= '0;
        rx_sh  <= '0;
      end else if (rx_cnt < wlen) begin
        rx_sh  <= rx_word;
        rx_cnt <= rx_cnt + 6'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_l       <= '0;
      play_left  <= '0;
      play_right <= '0;
      play_valid <= 1'b0;
    end else begin
      if (emit && !rx_lr) rx_l <= rx_word;
      if (emit && rx_lr) begin
        play_left  <= rx_l;
        play_right <= rx_word;
        play_valid <= 1'b1;
      end else if (play_ready) begin
        play_valid <= 1'b0;
      end
    end

  // R2
  cap_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(adc_dat));

  // R5
  cap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ready |=> !cap_ready);

  // R6
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ready && !cap_valid |=> underrun);

  // R6
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R8
  play_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid && !play_ready && !emit |=> play_valid && $stable(play_left) && $stable(play_right));

endmodule

// File: tb/tb_codec_audio_port.sv
module tb_codec_audio_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int NB = 40;

  logic clk = 0, rst_n = 0;
  logic master_mode = 0;
  logic [1:0] word_sel = 2'd2;
  logic bclk_in = 1, adc_lrc = 0, dac_lrc = 0, dac_dat = 0;
  logic [31:0] cap_left = 0, cap_right = 0;
  logic cap_valid = 0, play_ready = 0;
  logic bclk_out, bclk_oe, adc_dat, cap_ready, underrun, play_valid;
  logic [31:0] play_left, play_right;

  int checks = 0, bad = 0, hs = 0, acc = 0;
  logic [31:0] acc_l, acc_r;
  bit done = 0;

  codec_audio_port #(.BCLK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .word_sel(word_sel),
    .bclk_in(bclk_in), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
    .adc_lrc(adc_lrc), .adc_dat(adc_dat), .cap_left(cap_left), .cap_right(cap_right),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .underrun(underrun),
    .dac_lrc(dac_lrc), .dac_dat(dac_dat), .play_left(play_left), .play_right(play_right),
    .play_valid(play_valid), .play_ready(play_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (cap_valid && cap_ready) hs++;
    if (play_valid && play_ready) begin
      acc++;
      acc_l = play_left;
      acc_r = play_right;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wl(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 20 : (s == 2'd2) ? 24 : 32;
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] v, input int w);
    logic [63:0] m;
    m = (64'h1 << w) - 64'h1;
    return v & m[31:0];
  endfunction

  task automatic bfall();
    if (master_mode) begin
      @(negedge bclk_out);
      @(negedge clk);
    end else begin
      repeat (HALF) @(negedge clk);
      bclk_in = 0;
    end
  endtask

  task automatic brise();
    if (master_mode) begin
      @(posedge bclk_out);
      @(negedge clk);
    end else begin
      repeat (HALF) @(negedge clk);
      bclk_in = 1;
    end
  endtask

  task automatic run_half(input logic lr, input logic [31:0] pw, output logic [31:0] cw, output int pad);
    int w;
    w = wl(word_sel);
    cw = 0;
    pad = 0;
    for (int j = 0; j < NB; j++) begin
      bfall();
      adc_lrc = lr;
      dac_lrc = lr;
      dac_dat = (j >= 1 && j <= w) ? pw[w-j] : 1'b1;
      brise();
      if (j >= 1 && j <= w) cw[w-j] = adc_dat;
      else if (adc_dat) pad++;
    end
  endtask

  task automatic run_frame(input logic [31:0] pl, pr, output logic [31:0] cl, cr, output int pad);
    int p1, p2;
    run_half(1'b0, pl, cl, p1);
    run_half(1'b1, pr, cr, p2);
    pad = p1 + p2;
  endtask

  task automatic accept();
    @(negedge clk) play_ready = 1;
    @(negedge clk) play_ready = 0;
  endtask

  task automatic prime();
    logic [31:0] a, b;
    int p;
    run_half(1'b1, 32'h0, a, p);
    accept();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(adc_dat == 0, "R1 adc_dat", {31'b0, adc_dat}, 0);
    chk(cap_ready == 0, "R1 cap_ready", {31'b0, cap_ready}, 0);
    chk(play_valid == 0, "R1 play_valid", {31'b0, play_valid}, 0);
    chk(underrun == 0, "R1 underrun", {31'b0, underrun}, 0);
    chk(bclk_oe == 0, "R9 slave oe", {31'b0, bclk_oe}, 0);
  endtask

  task automatic t_frame(input logic [1:0] ws, input logic [31:0] cl_in, cr_in, pl, pr);
    logic [31:0] cl, cr;
    int pad, h0, w;
    word_sel = ws;
    w = wl(ws);
    cap_left = cl_in;
    cap_right = cr_in;
    cap_valid = 1;
    h0 = hs;
    run_frame(msk(pl, w), msk(pr, w), cl, cr, pad);
    chk(cl == msk(cl_in, w), "R2 R3 capture left", cl, msk(cl_in, w));
    chk(cr == msk(cr_in, w), "R2 R3 capture right", cr, msk(cr_in, w));
    chk(pad == 0, "R4 capture padding", pad, 0);
    chk(hs == h0 + 1, "R5 one capture handshake", hs - h0, 1);
    chk(play_valid == 1, "R8 play_valid", {31'b0, play_valid}, 1);
    chk(play_left == msk(pl, w), "R7 R3 playback left", play_left, msk(pl, w));
    chk(play_right == msk(pr, w), "R7 R3 playback right", play_right, msk(pr, w));
    accept();
    @(negedge clk);
    chk(play_valid == 0, "R8 cleared on ready", {31'b0, play_valid}, 0);
  endtask

  task automatic t_underrun();
    logic [31:0] cl, cr;
    int pad, h0;
    word_sel = 2'd0;
    cap_left = 32'h0000_1357;
    cap_right = 32'h0000_9BDF;
    cap_valid = 1;
    run_frame(32'h1, 32'h2, cl, cr, pad);
    accept();
    chk(underrun == 0, "R6 no underrun yet", {31'b0, underrun}, 0);
    cap_valid = 0;
    cap_left = 32'h0000_FFFF;
    h0 = hs;
    run_frame(32'h3, 32'h4, cl, cr, pad);
    accept();
    chk(cl == 32'h1357, "R6 repeat left", cl, 32'h1357);
    chk(cr == 32'h9BDF, "R6 repeat right", cr, 32'h9BDF);
    chk(underrun == 1, "R6 underrun set", {31'b0, underrun}, 1);
    chk(hs == h0, "R5 no handshake when invalid", hs - h0, 0);
    cap_valid = 1;
    cap_left = 32'h0000_2468;
    run_frame(32'h5, 32'h6, cl, cr, pad);
    accept();
    chk(cl == 32'h2468, "R5 new sample after underrun", cl, 32'h2468);
    chk(underrun == 1, "R6 underrun sticky", {31'b0, underrun}, 1);
  endtask

  task automatic t_overwrite();
    logic [31:0] cl, cr;
    int pad;
    word_sel = 2'd1;
    run_frame(32'h1_1111, 32'h2_2222, cl, cr, pad);
    run_frame(32'h3_3333, 32'h4_4444, cl, cr, pad);
    chk(play_left == 32'h3_3333, "R8 overwrite left", play_left, 32'h3_3333);
    chk(play_right == 32'h4_4444, "R8 overwrite right", play_right, 32'h4_4444);
    accept();
  endtask

  task automatic t_same_cycle();
    logic [31:0] cl, cr;
    int pad, a0;
    word_sel = 2'd2;
    a0 = acc;
    @(negedge clk) play_ready = 1;
    run_frame(32'h00AB_CDEF, 32'h0012_3456, cl, cr, pad);
    repeat (3) @(negedge clk);
    play_ready = 0;
    chk(acc == a0 + 1, "R8 one accept with ready held", acc - a0, 1);
    chk(acc_l == 32'h00AB_CDEF, "R8 accepted left", acc_l, 32'h00AB_CDEF);
    chk(acc_r == 32'h0012_3456, "R8 accepted right", acc_r, 32'h0012_3456);
    chk(play_valid == 0, "R8 valid dropped", {31'b0, play_valid}, 0);
  endtask

  task automatic t_master();
    longint t0, t1;
    @(negedge clk) master_mode = 1;
    @(negedge clk);
    chk(bclk_oe == 1, "R9 master oe", {31'b0, bclk_oe}, 1);
    @(posedge bclk_out) t0 = $time;
    @(posedge bclk_out) t1 = $time;
    chk((t1 - t0) == 2 * HALF * CLK_PERIOD, "R9 bclk period", 32'(t1 - t0), 32'(2 * HALF * CLK_PERIOD));
    prime();
    t_frame(2'd1, 32'hFFF5_A5A5, 32'h000C_3C3C, 32'h9_8765, 32'h1_0F0F);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    prime();
    t_frame(2'd2, 32'hAB12_3456, 32'hCD65_4321, 32'h00FE_DCBA, 32'h0080_0001);
    t_frame(2'd0, 32'h1234_8001, 32'hFFFF_7FFE, 32'h0000_C001, 32'h0000_0F0F);
    t_frame(2'd3, 32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF, 32'h0123_4567);
    t_underrun();
    t_overwrite();
    t_same_cycle();
    t_master();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule